// File: doc/BRIEF.md
# Retransmit-Capable FIFO Buffer

This block is a first-in first-out store of 4096 words, each 9 bits wide. The ninth bit is meant to hold a parity bit. Two internal pointers generate the storage addresses, so the user supplies none. The user pulls an active-low write strobe low to store the word on the data input. The user pulls an active-low read strobe low to fetch the oldest stored word. Both strobes are sampled on one system clock, and only a high-to-low change of a strobe counts as an access.

Three status flags report occupancy: empty, full and half-full. A full buffer refuses writes and an empty buffer refuses reads. This protects the contents from overrun and underflow. A rewind input moves the read pointer back to location zero, so a frame that has already been read can be read again. The write pointer and the stored words are not changed by a rewind. A rewind gives a correct frame only while the written data has not wrapped past the last location.

Top module: `fifo_rt`

## Requirements
- R1: Words leave the buffer in the order they were written. All 9 data bits are preserved, and up to 4096 words can be held.
- R2: An access is taken only on a high-to-low change of `wr_n` or `rd_n`, as sampled on the rising clock edge. A strobe held low for many cycles gives exactly one access. The strobe history is cleared to high by reset.
- R3: `empty` is 1 exactly when no words are stored. A read strobe while empty is ignored: `rd_data` holds and the occupancy does not change.
- R4: `full` is 1 exactly when 4096 words are stored. A write strobe while full is ignored, and no stored word is overwritten.
- R5: `half_full` is 1 exactly when 2048 or more words are stored.
- R6: `rd_data` takes the read word on the same clock edge that accepts the read. At every other edge it holds its value.
- R7: A read and a write in the same cycle are both accepted when the buffer is neither empty nor full, and the occupancy stays the same. When the buffer is empty only the write is taken. When it is full only the read is taken.
- R8: `rewind` high at a clock edge does four things. It sets the read pointer to location 0. It sets the occupancy to the write pointer value, counted after any write in that cycle (range 0 to 4095). It ignores a read strobe in that cycle. It still accepts a write in that cycle.
- R9: While `rst_n` is low at a clock edge, both pointers and the occupancy are cleared. The flags then read empty=1, full=0, half_full=0, and `rd_data` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low, falling change triggers a write |
| rd_n | input | 1 | Read strobe, active low, falling change triggers a read |
| rewind | input | 1 | Moves the read pointer back to location 0 |
| wr_data | input | 9 | Word to store |
| rd_data | output | 9 | Last word read, registered |
| empty | output | 1 | No words stored |
| full | output | 1 | 4096 words stored |
| half_full | output | 1 | At least 2048 words stored |

## Verification
Each accepted access updates the pointers, the occupancy and the flags at the same rising edge that samples the strobe change. `rd_data` is also registered on that edge, so every result is due one edge after the stimulus is applied.

The bench changes its inputs only at falling edges. It advances a behavioural model once per rising edge and compares the flags and `rd_data` at the next falling edge. This keeps the check exactly one cycle after the stimulus.

Directed checks cover the following cases:
- a strobe held low for several cycles;
- the half-full threshold;
- refused accesses at both ends of the buffer;
- combined read and write;
- rewind with and without a write in the same cycle.

// File: rtl/fifo_rt_pkg.sv
// Shared constants for the retransmit FIFO.
// Assumes: depth is a power of two.
package fifo_rt_pkg;
    localparam int DEF_DEPTH = 4096;
    localparam int DEF_WIDTH = 9;
    localparam int LANES     = 2;

    // Position of each strobe in the edge detector's lane vector.
    typedef enum int {
        LANE_WR = 0,
        LANE_RD = 1
    } lane_e;
endpackage

// File: rtl/fifo_rt_strobe.sv
// Falling-edge detector for active-low strobes sampled on clk.
// Emits a one-cycle pulse in the cycle a strobe is first seen low.
// Assumes: strobes are already synchronous to clk.
module fifo_rt_strobe #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_n;

    for (genvar i = 0; i < N; i++) begin : g_lane
        // Remember last sampled level; idle (high) after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_n[i] <= 1'b1;
            else        prev_n[i] <= strobe_n[i];
        end

        assign fall[i] = prev_n[i] & ~strobe_n[i];

        AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            fall[i] |=> !fall[i]); // R2
    end
endmodule

// File: rtl/fifo_rt_ctrl.sv
// Pointer and occupancy control for the retransmit FIFO.
// Accepts write/read requests, refuses them when full/empty,
// and handles rewind of the read pointer to location zero.
// Assumes: DEPTH is a power of two; requests are single-cycle pulses.
module fifo_rt_ctrl #(
    parameter int DEPTH = 4096
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_req,
    input  logic                     rd_req,
    input  logic                     rewind,
    output logic                     wr_ok,
    output logic                     rd_ok,
    output logic [$clog2(DEPTH)-1:0] wr_addr,
    output logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic                     empty,
    output logic                     full,
    output logic                     half_full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    assign empty     = (cnt == '0);
    assign full      = (cnt == CW'(DEPTH));
    assign half_full = (cnt >= CW'(DEPTH / 2));
    assign wr_ok     = wr_req & ~full;
    assign rd_ok     = rd_req & ~empty & ~rewind;
    assign wr_addr   = wp;
    assign rd_addr   = rp;

    // Advance the write pointer on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)     wp <= '0;
        else if (wr_ok) wp <= wp + 1'b1;
    end

    // Move the read pointer and occupancy; rewind takes priority over a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp  <= '0;
            cnt <= '0;
        end else if (rewind) begin
            rp  <= '0;
            cnt <= {1'b0, wp + AW'(wr_ok)};
        end else begin
            if (rd_ok) rp <= rp + 1'b1;
            cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R4
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && !rd_req && !rewind) |=> (full && wp == $past(wp))); // R4
    AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_req && !wr_req && !rewind) |=> (empty && rp == $past(rp))); // R3
    AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && rd_ok) |=> (cnt == $past(cnt))); // R7
    AST_REWIND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (rp == '0)); // R8
    AST_FULL_IS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (half_full && !empty)); // R5
endmodule

// File: rtl/fifo_rt_store.sv
// Word storage with one write port and one registered read port.
// Assumes: the controller never writes and reads the same address in one cycle.
module fifo_rt_store #(
    parameter int DEPTH = 4096,
    parameter int WIDTH = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic                     re,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WIDTH-1:0]         rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store the incoming word on an accepted write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Register the addressed word on an accepted read; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata)); // R6
endmodule

// File: rtl/fifo_rt.sv
// Top of the retransmit FIFO: strobe edge detection, control, storage.
// Assumes: wr_n, rd_n and rewind are synchronous to clk.
module fifo_rt
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             rewind,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic             half_full
);
    localparam int AW = $clog2(DEPTH);

    logic [LANES-1:0] strobe_n, fall;
    logic             wr_ok, rd_ok;
    logic [AW-1:0]    wr_addr, rd_addr;

    assign strobe_n[LANE_WR] = wr_n;
    assign strobe_n[LANE_RD] = rd_n;

    fifo_rt_strobe #(.N(LANES)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .fall     (fall)
    );

    fifo_rt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (fall[LANE_WR]),
        .rd_req    (fall[LANE_RD]),
        .rewind    (rewind),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .empty     (empty),
        .full      (full),
        .half_full (half_full)
    );

    fifo_rt_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok),
        .waddr (wr_addr),
        .wdata (wr_data),
        .re    (rd_ok),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: tb/tb_fifo_rt.sv
`timescale 1ns/1ps
module tb_fifo_rt;
    localparam int DEPTH = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1, rd_n = 1'b1, rewind = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       empty, full, half_full;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    // Behavioural reference state.
    int m_mem[DEPTH];
    int m_wp = 0, m_rp = 0, m_cnt = 0, m_dout = 0;
    bit m_pw = 1, m_pr = 1;

    fifo_rt dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rewind(rewind),
        .wr_data(wr_data), .rd_data(rd_data), .empty(empty), .full(full),
        .half_full(half_full)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Reference model for one rising edge.
    task automatic model_edge();
        bit wf, rf, wok, rok;
        if (!rst_n) begin
            m_wp = 0; m_rp = 0; m_cnt = 0; m_dout = 0; m_pw = 1; m_pr = 1;
        end else begin
            wf = m_pw && !wr_n;
            rf = m_pr && !rd_n;
            m_pw = wr_n;
            m_pr = rd_n;
            wok = wf && (m_cnt < DEPTH);
            rok = rf && (m_cnt > 0) && !rewind;
            if (wok) begin
                m_mem[m_wp] = int'(wr_data);
                m_wp = (m_wp + 1) % DEPTH;
            end
            if (rewind) begin
                m_rp = 0;
                m_cnt = m_wp;
            end else begin
                if (rok) begin
                    m_dout = m_mem[m_rp];
                    m_rp = (m_rp + 1) % DEPTH;
                end
                m_cnt = m_cnt + int'(wok) - int'(rok);
            end
        end
    endtask

    // Drive inputs, advance one clock, compare at the falling edge.
    task automatic step(input bit w, input bit r, input bit rw, input int d);
        wr_n = w; rd_n = r; rewind = rw; wr_data = 9'(d);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(empty == (m_cnt == 0), "R3", "empty", int'(empty), int'(m_cnt == 0));
        chk(full == (m_cnt == DEPTH), "R4", "full", int'(full), int'(m_cnt == DEPTH));
        chk(half_full == (m_cnt >= DEPTH / 2), "R5", "half_full",
            int'(half_full), int'(m_cnt >= DEPTH / 2));
        chk(int'(rd_data) == m_dout, "R1", "rd_data", int'(rd_data), m_dout);
    endtask

    task automatic pulse_wr(input int d);
        step(0, 1, 0, d);
        step(1, 1, 0, d);
    endtask

    task automatic pulse_rd();
        step(1, 0, 0, 0);
        step(1, 1, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        step(1, 1, 0, 0);
        step(1, 1, 0, 0);
        rst_n = 1;
    endtask

    function automatic int pat(input int i);
        return (i * 37 + 5) % 512;
    endfunction

    // Watchdog: an expired run counts as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R9: reset state
        chk(empty && !full && !half_full && rd_data == 0, "R9", "reset flags/data",
            int'({empty, full, half_full}), 4);

        // R2: strobe held low for five cycles gives one write only
        for (int k = 0; k < 5; k++) step(0, 1, 0, 9'h1A5);
        step(1, 1, 0, 0);
        pulse_rd();
        chk(rd_data == 9'h1A5 && empty, "R2", "held strobe single access",
            int'(rd_data), 9'h1A5);

        // R3: read while empty ignored, data holds
        pulse_rd();
        chk(rd_data == 9'h1A5 && empty, "R3", "read while empty", int'(rd_data), 9'h1A5);

        // R1/R6: small burst in order
        for (int i = 0; i < 4; i++) pulse_wr(pat(i));
        for (int i = 0; i < 4; i++) begin
            step(1, 0, 0, 0);
            chk(int'(rd_data) == pat(i), "R6", "data one edge after read",
                int'(rd_data), pat(i));
            step(1, 1, 0, 0);
        end

        // R7: simultaneous read and write on an empty buffer: write only
        step(0, 0, 0, 9'h0F0);
        step(1, 1, 0, 0);
        chk(!empty && rd_data == int'(pat(3)), "R7", "empty both -> write only",
            int'(empty), 0);
        pulse_wr(9'h0F1);
        step(0, 0, 0, 9'h0F2);   // both accepted
        chk(int'(rd_data) == 9'h0F0, "R7", "both accepted read data",
            int'(rd_data), 9'h0F0);
        step(1, 1, 0, 0);
        pulse_rd(); pulse_rd();
        chk(int'(rd_data) == 9'h0F2 && empty, "R7", "order after combined access",
            int'(rd_data), 9'h0F2);

        // R8: rewind replays from location zero
        do_reset();
        for (int i = 0; i < 6; i++) pulse_wr(pat(i + 10));
        for (int i = 0; i < 3; i++) pulse_rd();
        step(1, 0, 1, 0);        // read in rewind cycle ignored
        chk(int'(rd_data) == pat(12), "R8", "read ignored on rewind",
            int'(rd_data), pat(12));
        step(1, 1, 0, 0);
        for (int i = 0; i < 6; i++) begin
            pulse_rd();
            chk(int'(rd_data) == pat(i + 10), "R8", "replayed word",
                int'(rd_data), pat(i + 10));
        end
        chk(empty, "R8", "empty after replay", int'(empty), 1);
        step(0, 1, 1, 9'h033);   // rewind together with a write
        step(1, 1, 0, 0);
        for (int i = 0; i < 7; i++) pulse_rd();
        chk(int'(rd_data) == 9'h033 && empty, "R8", "write kept in rewind cycle",
            int'(rd_data), 9'h033);

        // R4/R5: fill to the half and full thresholds
        do_reset();
        for (int i = 0; i < DEPTH / 2 - 1; i++) pulse_wr(pat(i));
        chk(!half_full, "R5", "below half", int'(half_full), 0);
        pulse_wr(pat(DEPTH / 2 - 1));
        chk(half_full, "R5", "at half", int'(half_full), 1);
        for (int i = DEPTH / 2; i < DEPTH; i++) pulse_wr(pat(i));
        chk(full, "R4", "full at depth", int'(full), 1);
        pulse_wr(9'h1FF);        // refused
        chk(full, "R4", "write while full", int'(full), 1);
        step(0, 0, 0, 9'h1FE);   // full: read only
        step(1, 1, 0, 0);
        chk(!full && int'(rd_data) == pat(0), "R7", "full both -> read only",
            int'(rd_data), pat(0));
        for (int i = 1; i < DEPTH; i++) pulse_rd();
        chk(empty && int'(rd_data) == pat(DEPTH - 1), "R1", "last word of full drain",
            int'(rd_data), pat(DEPTH - 1));

        finish_run();
    end
endmodule